// File: doc/BRIEF.md
# Memory controller performance counter unit

This unit counts activity in a memory controller so that software can work out bandwidth and efficiency. It holds a set of event counters, four by default. Counter 0 is the master cycle counter. Counters 1 and up each count one event, picked by an 8-bit select code. The controller supplies the events as a vector of one-clock pulses, with one bit for each select code. Software reaches the unit over a simple word-aligned register bus. A write is a single strobed cycle. A read is combinational on the current address.

The master counter gates the whole unit. The other counters advance only while counter 0 is enabled and has not wrapped. When counter 0 wraps, every counter freezes, an overflow flag is set, and a level interrupt is raised. Software then reads all the counts. It restarts the unit by writing zero and then enable-with-clear. The event counters wrap silently.

Top module: `perf_counter_unit`

## Requirements
- R1: After reset every control and count register reads 0 and `irq` is low.
- R2: The unit decodes these byte addresses:
  - Counter n has a control register at 0x00+4n and a count register at 0x20+4n.
  - A control register reads as: bits 31:24 the select code, bit 2 the enable, bit 0 the overflow flag. The overflow flag exists for counter 0 only. Bit 1 (clear) and all other bits read 0.
  - A count register reads as its value, zero-extended.
  - Writes to a count register are ignored.
  - An address with bits 1:0 not zero, or outside both windows, reads 0 and ignores writes.
- R3: A non-zero write to the control register of a disabled counter takes bit 2 as the enable and bits 31:24 as the code. If bit 1 is set, the count becomes 0 on that clock.
- R4: Writing zero to a control register clears its enable and code. For counter 0 it also clears the overflow flag. The count value is kept.
- R5: A non-zero write to an enabled counter's control register changes nothing. In any clock in which a counter's control register is written, that counter does not advance.
- R6: Counter 0 adds 1 on every clock in which it is enabled and its overflow flag is clear, whatever its code.
- R7: Counter k (k ≥ 1) adds 1 on a clock when all four of these hold: it is enabled, counter 0 is running (enabled with the flag clear), its code is not 0, and `evt_pulse[code]` is high. A code of 0, or a code at or above NUM_EVT, never counts.
- R8: While counter 0 is disabled, no counter changes, except through its own control writes.
- R9: Counters 1 and up wrap from 2^CNT_W−1 to 0, keep counting, and raise no interrupt.
- R10: When counter 0 advances from 2^CNT_W−1 it becomes 0 and sets the overflow flag. `irq` rises on the next cycle, and every counter then holds.
- R11: `irq` is high exactly while the overflow flag is set. It is low on the cycle after a zero write to counter 0's control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| evt_pulse | input | NUM_EVT | Event pulses, bit i is select code i |
| irq | output | 1 | Level interrupt, set on a cycle-counter wrap |

## Verification
A wrong run/freeze state shows up as a count that differs from the reference one cycle after the clock it went wrong on. Each count register read then reveals it, so it is caught at the next full register sweep. A wrong overflow flag shows directly on `irq` and on bit 0 of counter 0's control register on the cycle after the wrap. Mis-gated event selects, including code 0 and codes past the last event line, show up as counts that drift away from the reference under random event traffic. Dropped or wrongly accepted control writes show up on the next readback of that control register.

// File: rtl/pcu_pkg.sv
// Package: shared constants for the performance counter unit.
// Assumes byte addressing with word-aligned registers.
package pcu_pkg;
    localparam int unsigned CODE_W          = 8;
    localparam int unsigned CODE_LSB        = 24;
    localparam int unsigned BIT_OVF         = 0;
    localparam int unsigned BIT_CLR         = 1;
    localparam int unsigned BIT_EN          = 2;
    localparam int unsigned COUNT_BASE_WORD = 8;
    localparam int unsigned SEL_SPACE       = 1 << CODE_W;
    typedef logic [CODE_W-1:0] evt_code_t;
endpackage

// File: rtl/pcu_bus_decode.sv
// Module: pcu_bus_decode
// Decodes a byte address into a per-counter control-write strobe and a read
// selection. Only aligned addresses (bits 1:0 zero) hit a register.
// Assumes NUM_CNT <= 8, so that each window is 8 words.
module pcu_bus_decode #(
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned NUM_CNT = 4,
    localparam int unsigned IDX_W  = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1
) (
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    output logic [NUM_CNT-1:0] ctrl_wr,
    output logic               rd_is_ctrl,
    output logic               rd_is_cnt,
    output logic [IDX_W-1:0]   rd_idx
);
    import pcu_pkg::*;

    localparam int unsigned WIDX_W = ADDR_W - 2;

    logic [WIDX_W-1:0] widx;
    logic              aligned;

    assign widx    = bus_addr[ADDR_W-1:2];
    assign aligned = (bus_addr[1:0] == 2'b00);

    // Region decode for the control and count windows.
    always_comb begin
        rd_is_ctrl = aligned && (widx < WIDX_W'(NUM_CNT));
        rd_is_cnt  = aligned && (widx >= WIDX_W'(COUNT_BASE_WORD))
                             && (widx < WIDX_W'(COUNT_BASE_WORD + NUM_CNT));
        rd_idx     = widx[IDX_W-1:0];
    end

    // One write strobe per control register.
    always_comb begin
        for (int n = 0; n < NUM_CNT; n++) begin
            ctrl_wr[n] = bus_wr && rd_is_ctrl && (widx == WIDX_W'(n));
        end
    end
endmodule

// File: rtl/pcu_ctrl_reg.sv
// Module: pcu_ctrl_reg
// Holds the enable bit and select code of one counter.
// - A zero write clears the register.
// - A non-zero write is taken only while the counter is disabled; an enabled
//   counter ignores it.
// - clr_o pulses on an accepted write that has the clear bit set.
module pcu_ctrl_reg (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              wr_zero,
    input  logic              wr_en,
    input  logic              wr_clr,
    input  pcu_pkg::evt_code_t wr_code,
    output logic              en_o,
    output pcu_pkg::evt_code_t code_o,
    output logic              clr_o
);
    import pcu_pkg::*;

    logic load;

    assign load  = wr && !wr_zero && !en_o;
    assign clr_o = load && wr_clr;

    // Control state update: a zero write stops the counter, a load arms it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_o   <= 1'b0;
            code_o <= '0;
        end else if (wr && wr_zero) begin
            en_o   <= 1'b0;
            code_o <= '0;
        end else if (load) begin
            en_o   <= wr_en;
            code_o <= wr_code;
        end
    end
endmodule

// File: rtl/pcu_evt_sel.sv
// Module: pcu_evt_sel
// Picks the event pulse named by a select code.
// Code 0 and codes at or above NUM_EVT never hit.
// Assumes NUM_EVT <= 256.
module pcu_evt_sel #(
    parameter int unsigned NUM_EVT = 64
) (
    input  pcu_pkg::evt_code_t  code,
    input  logic [NUM_EVT-1:0]  evt,
    output logic                hit
);
    import pcu_pkg::*;

    logic [SEL_SPACE-1:0] wide;

    // Zero-extend the event lines so that every code has a defined bit.
    assign wide = SEL_SPACE'(evt);

    // Select the event line; code 0 is reserved for cycles.
    assign hit = (code != '0) && wide[code];
endmodule

// File: rtl/pcu_counter.sv
// Module: pcu_counter
// One wrapping up-counter.
// - Clear has priority over increment.
// - hold suppresses the increment in the cycle the counter's control
//   register is written.
module pcu_counter #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic             hold,
    output logic [CNT_W-1:0] cnt_o
);
    // Count register: reset, clear, or advance modulo 2^CNT_W.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (clr) begin
            cnt_o <= '0;
        end else if (inc && !hold) begin
            cnt_o <= cnt_o + 1'b1;
        end
    end
endmodule

// File: rtl/perf_counter_unit.sv
// Module: perf_counter_unit (top)
// Performance counter unit.
// - Counter 0 counts clocks and gates all the others.
// - Counters 1 and up count selected event pulses.
// - A wrap of counter 0 sets the overflow flag, which freezes the unit and
//   drives irq.
// Assumes CNT_W <= 32, NUM_CNT <= 8, NUM_EVT <= 256.
module perf_counter_unit #(
    parameter int unsigned NUM_CNT = 4,
    parameter int unsigned CNT_W   = 32,
    parameter int unsigned NUM_EVT = 64,
    parameter int unsigned ADDR_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [NUM_EVT-1:0] evt_pulse,
    output logic               irq
);
    import pcu_pkg::*;

    localparam int unsigned IDX_W = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1;

    logic [NUM_CNT-1:0]            ctrl_wr;
    logic                          rd_is_ctrl;
    logic                          rd_is_cnt;
    logic [IDX_W-1:0]              rd_idx;
    logic                          wr_zero;
    logic                          wr_en;
    logic                          wr_clr;
    evt_code_t                     wr_code;
    logic [NUM_CNT-1:0]            en;
    evt_code_t                     code [NUM_CNT];
    logic [NUM_CNT-1:0]            clr;
    logic [NUM_CNT-1:0]            hit;
    logic [NUM_CNT-1:0]            inc;
    logic [NUM_CNT-1:0][CNT_W-1:0] cnt;
    logic                          ovf_q;
    logic                          run;
    logic                          wrap0;

    // Write-data field split shared by all control registers.
    assign wr_zero = (bus_wdata == 32'd0);
    assign wr_en   = bus_wdata[BIT_EN];
    assign wr_clr  = bus_wdata[BIT_CLR];
    assign wr_code = bus_wdata[CODE_LSB +: CODE_W];

    pcu_bus_decode #(
        .ADDR_W (ADDR_W),
        .NUM_CNT(NUM_CNT)
    ) u_dec (
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .ctrl_wr   (ctrl_wr),
        .rd_is_ctrl(rd_is_ctrl),
        .rd_is_cnt (rd_is_cnt),
        .rd_idx    (rd_idx)
    );

    // The master runs while enabled and not yet wrapped.
    assign run = en[0] && !ovf_q;

    for (genvar n = 0; n < NUM_CNT; n++) begin : g_cnt
        pcu_ctrl_reg u_ctrl (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr     (ctrl_wr[n]),
            .wr_zero(wr_zero),
            .wr_en  (wr_en),
            .wr_clr (wr_clr),
            .wr_code(wr_code),
            .en_o   (en[n]),
            .code_o (code[n]),
            .clr_o  (clr[n])
        );

        if (n == 0) begin : g_master
            // The master's event is the clock itself.
            assign hit[n] = 1'b1;
        end else begin : g_event
            pcu_evt_sel #(
                .NUM_EVT(NUM_EVT)
            ) u_sel (
                .code(code[n]),
                .evt (evt_pulse),
                .hit (hit[n])
            );
        end

        assign inc[n] = run && en[n] && hit[n];

        pcu_counter #(
            .CNT_W(CNT_W)
        ) u_count (
            .clk  (clk),
            .rst_n(rst_n),
            .clr  (clr[n]),
            .inc  (inc[n]),
            .hold (ctrl_wr[n]),
            .cnt_o(cnt[n])
        );
    end

    assign wrap0 = inc[0] && !ctrl_wr[0] && (&cnt[0]);

    // Overflow flag: set on a master wrap, cleared by a zero write to control 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
        end else if (ctrl_wr[0] && wr_zero) begin
            ovf_q <= 1'b0;
        end else if (wrap0) begin
            ovf_q <= 1'b1;
        end
    end

    assign irq = ovf_q;

    // Read mux: control fields or a zero-extended count.
    always_comb begin
        bus_rdata = 32'd0;
        if (rd_is_ctrl) begin
            bus_rdata[CODE_LSB +: CODE_W] = code[rd_idx];
            bus_rdata[BIT_EN]             = en[rd_idx];
            bus_rdata[BIT_OVF]            = (rd_idx == '0) && ovf_q;
        end else if (rd_is_cnt) begin
            bus_rdata[CNT_W-1:0] = cnt[rd_idx];
        end
    end
endmodule

// File: rtl/pcu_checker.sv
// Module: pcu_checker
// Property checks for perf_counter_unit, attached to it through bind.
module pcu_checker #(
    parameter int unsigned NUM_CNT = 4,
    parameter int unsigned CNT_W   = 32,
    parameter int unsigned ADDR_W  = 8
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          bus_wr,
    input logic [ADDR_W-1:0]             bus_addr,
    input logic [31:0]                   bus_wdata,
    input logic                          irq,
    input logic [NUM_CNT-1:0][CNT_W-1:0] cnt,
    input logic                          en0,
    input logic                          run
);
    logic wr_ctrl0;
    assign wr_ctrl0 = bus_wr && (bus_addr == '0);

    // R10
    cyc_wrap_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && (&cnt[0]) && !wr_ctrl0) |=> irq);

    // R10
    frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !bus_wr) |=> $stable(cnt));

    // R11
    irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl0 && (bus_wdata == 32'd0)) |=> !irq);

    // R8
    master_off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en0 && !bus_wr) |=> $stable(cnt));

    for (genvar k = 0; k < NUM_CNT; k++) begin : g_step
        // R9
        unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(cnt[k]) |-> ((cnt[k] == CNT_W'($past(cnt[k]) + 1'b1))
                                  || (cnt[k] == '0)));
    end
endmodule

bind perf_counter_unit pcu_checker #(
    .NUM_CNT(NUM_CNT),
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .irq      (irq),
    .cnt      (cnt),
    .en0      (en[0]),
    .run      (run)
);

// File: tb/perf_counter_unit_tb.sv
`timescale 1ns/100ps
// Bench: directed corner cases plus seeded random traffic, checked against a
// reference model written from the requirements. A narrow counter width lets
// the wrap cases run quickly.
module perf_counter_unit_tb;
    localparam int CW = 10;
    localparam int NE = 64;
    localparam logic [CW-1:0] CMAX = '1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        b_wr = 1'b0;
    logic [7:0]  b_addr = '0;
    logic [31:0] b_wdata = '0;
    logic [31:0] b_rdata;
    logic [NE-1:0] b_evt = '0;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic          m_en [4];
    logic [7:0]    m_code [4];
    logic [CW-1:0] m_cnt [4];
    logic          m_ovf;

    always #5 clk = ~clk;

    perf_counter_unit #(.NUM_CNT(4), .CNT_W(CW), .NUM_EVT(NE), .ADDR_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(b_wr), .bus_addr(b_addr),
        .bus_wdata(b_wdata), .bus_rdata(b_rdata), .evt_pulse(b_evt), .irq(irq));

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Reference step, applied at each rising edge out of reset.
    task automatic model_step();
        logic run;
        logic inc;
        int idx;
        run = m_en[0] && !m_ovf;
        idx = -1;
        if (b_wr && b_addr[1:0] == 2'b00 && b_addr[7:2] < 6'd4) idx = int'(b_addr[7:2]);
        for (int n = 0; n < 4; n++) begin
            if (n == idx) begin
                if (b_wdata == 32'd0) begin
                    m_en[n] = 1'b0; m_code[n] = '0;
                    if (n == 0) m_ovf = 1'b0;
                end else if (!m_en[n]) begin
                    m_en[n] = b_wdata[2];
                    m_code[n] = b_wdata[31:24];
                    if (b_wdata[1]) m_cnt[n] = '0;
                end
            end else begin
                if (n == 0) inc = run;
                else begin
                    inc = 1'b0;
                    if (run && m_en[n] && m_code[n] != 8'd0 && m_code[n] < 8'(NE))
                        inc = b_evt[m_code[n][5:0]];
                end
                if (inc) begin
                    if (n == 0 && m_cnt[0] == CMAX) m_ovf = 1'b1;
                    m_cnt[n] = m_cnt[n] + 1'b1;
                end
            end
        end
    endtask

    function automatic logic [31:0] model_read(logic [7:0] a);
        logic [31:0] v;
        int w;
        v = '0;
        w = int'(a[7:2]);
        if (a[1:0] == 2'b00) begin
            if (w < 4) begin
                v[31:24] = m_code[w];
                v[2] = m_en[w];
                v[0] = (w == 0) && m_ovf;
            end else if (w >= 8 && w < 12) begin
                v[CW-1:0] = m_cnt[w-8];
            end
        end
        return v;
    endfunction

    // One clock with the given bus and event inputs.
    task automatic cycle(logic wr, logic [7:0] a, logic [31:0] d, logic [NE-1:0] e);
        b_wr = wr; b_addr = a; b_wdata = d; b_evt = e;
        @(posedge clk);
        model_step();
        #1;
        b_wr = 1'b0; b_evt = '0;
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        cycle(1'b1, a, d, '0);
    endtask

    task automatic rd_chk(string tag, logic [7:0] a);
        b_addr = a;
        #0.2;
        chk(tag, b_rdata, model_read(a));
    endtask

    // Sweep of every register plus a few unmapped or misaligned addresses.
    task automatic check_all(string tag);
        for (int w = 0; w < 16; w++) rd_chk(tag, 8'(w * 4));
        rd_chk(tag, 8'h05);
        rd_chk(tag, 8'h42);
        chk(tag, {31'd0, irq}, {31'd0, m_ovf});
    endtask

    function automatic logic [NE-1:0] rnd_evt();
        return {$urandom, $urandom};
    endfunction

    initial begin
        #1500000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        if (!done) $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int n = 0; n < 4; n++) begin
            m_en[n] = 1'b0; m_code[n] = '0; m_cnt[n] = '0;
        end
        m_ovf = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        check_all("R1");

        // R6: cycle counter runs; others disabled (R8 side: still zero)
        wr(8'h00, 32'h0000_0006);
        repeat (20) cycle(1'b0, 8'h00, 0, rnd_evt());
        check_all("R6");

        // R3 / R7: arm event counters, incl. last code and an out-of-range code
        wr(8'h04, 32'h0500_0006);
        wr(8'h08, 32'h3F00_0006);
        wr(8'h0C, 32'h5000_0006);
        check_all("R3");
        repeat (100) cycle(1'b0, 8'h00, 0, rnd_evt());
        check_all("R7");

        // R5: re-enable without zero write is ignored
        wr(8'h04, 32'h0700_0006);
        rd_chk("R5", 8'h04);
        check_all("R5");

        // R4: zero write disables, keeps count
        wr(8'h04, 32'h0);
        repeat (10) cycle(1'b0, 8'h00, 0, '1);
        check_all("R4");

        // R3: enable with clear zeroes the count
        wr(8'h04, 32'h0500_0006);
        check_all("R3");

        // R7: code 0 never counts
        wr(8'h04, 32'h0);
        wr(8'h04, 32'h0000_0006);
        repeat (50) cycle(1'b0, 8'h00, 0, '1);
        check_all("R7");

        // R2: misaligned write and count-register write are ignored
        wr(8'h09, 32'h0);
        wr(8'h24, 32'h0);
        wr(8'h21, 32'hFFFF_FFFF);
        check_all("R2");

        // R8: master disabled, events present, nothing moves
        wr(8'h00, 32'h0);
        repeat (30) cycle(1'b0, 8'h00, 0, '1);
        check_all("R8");

        // R9: counter 2 wraps while master is restarted periodically
        wr(8'h00, 32'h0000_0006);
        for (int r = 0; r < 3; r++) begin
            repeat (600) cycle(1'b0, 8'h00, 0, '1);
            wr(8'h00, 32'h0);
            wr(8'h00, 32'h0000_0006);
        end
        check_all("R9");
        chk("R9", {31'd0, irq}, 32'd0);

        // R10: master wrap freezes the unit and raises irq
        repeat (1100) cycle(1'b0, 8'h00, 0, '1);
        chk("R10", {31'd0, irq}, 32'd1);
        rd_chk("R10", 8'h00);
        check_all("R10");
        repeat (40) cycle(1'b0, 8'h00, 0, '1);
        check_all("R10");

        // R11: zero write to control 0 drops irq
        wr(8'h00, 32'h0);
        chk("R11", {31'd0, irq}, 32'd0);
        check_all("R11");

        // Random mix of writes and events
        for (int c = 0; c < 6000; c++) begin
            if (($urandom % 10) == 0) begin
                logic [31:0] d;
                logic [7:0] a;
                case ($urandom % 4)
                    0: d = 32'h0;
                    1: d = {8'($urandom % 72), 24'h000006};
                    2: d = {8'($urandom % 72), 24'h000004};
                    default: d = $urandom;
                endcase
                a = 8'($urandom % 64);
                if (($urandom % 2) == 0) a = {a[7:2], 2'b00};
                cycle(1'b1, a, d, rnd_evt());
            end else begin
                cycle(1'b0, 8'h00, 0, rnd_evt());
            end
            if ((c % 250) == 249) check_all("R7");
        end
        check_all("R3");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule